// File: doc/BRIEF.md
# Flash Block Lock Manager

This block keeps a protection state for every erase block of a boot-block flash array. It decides whether a program or erase on a given word address may proceed. The command decoder sends it lock commands that have already been decoded. Each command names an operation and any word address inside the target block. The block applies the command to that block's state. A hardware guard input decides whether a block that has been pinned by a lock-down can be released again.

The address space uses a bottom-boot layout. A run of small parameter blocks starts at address zero, and the remainder of the space is filled with equally sized main blocks. With the default parameters there are eight 4-KWord parameter blocks and sixty-three 32-KWord main blocks, 71 blocks in total. A modify request is answered in the same cycle through an allow flag. A denied request raises a one-cycle protection-error pulse on the next cycle, which the status register can capture. A separate read address returns the lock status word of any block for electronic-signature reads.

Top module: `flk_lock_mgr`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) puts every block in the locked state, including blocks that were locked-down.
- R2: A word address below NUM_PARAM*2^PARAM_AW selects block address>>PARAM_AW. Any higher address selects block NUM_PARAM + ((address - NUM_PARAM*2^PARAM_AW) >> MAIN_AW).
- R3: Operation code 2'b01 (lock) moves an unlocked block to locked. It leaves a locked-down block locked-down.
- R4: Operation code 2'b10 (unlock) moves a locked block to unlocked. It also releases a locked-down block when guard_n is high.
- R5: Operation code 2'b11 (lock-down) moves a block from any state to locked-down.
- R6: While guard_n is low, an unlock on a locked-down block has no effect.
- R7: Operation code 2'b00 has no effect, and a command changes only the block that cmd_addr selects.
- R8: A command sampled with cmd_valid high at a clock edge is visible on mod_allow and sig_status directly after that edge.
- R9: mod_allow is high exactly when the block selected by mod_addr is unlocked. It follows mod_addr in the same cycle.
- R10: prot_err is high for one cycle after an edge at which mod_req was high and mod_allow was low. It is low otherwise.
- R11: In sig_status, bit 0 is 1 for a locked or a locked-down block, bit 1 is 1 only for a locked-down block, and all higher bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded lock command is present this cycle |
| cmd_op | input | 2 | Operation: 00 none, 01 lock, 10 unlock, 11 lock-down |
| cmd_addr | input | ADDR_W | Any word address inside the target block |
| guard_n | input | 1 | Low keeps locked-down blocks pinned |
| mod_req | input | 1 | A program or erase attempt is made this cycle |
| mod_addr | input | ADDR_W | Word address of the program or erase attempt |
| mod_allow | output | 1 | The block at mod_addr is unlocked |
| prot_err | output | 1 | One-cycle pulse after a denied modify request |
| sig_addr | input | ADDR_W | Word address for a lock status read |
| sig_status | output | SIG_W | Lock status word of the block at sig_addr |

## Verification
The bench builds the block with a 12-bit address, 64-word parameter blocks and 512-word main blocks. That gives eight parameter blocks plus seven main blocks. Every block can then be probed after reset, and both edges of the parameter-to-main boundary and the very last word of the space each get their own probe. These shrunken sizes leave the mapping arithmetic and the per-block state logic the same as in the default build, so all lock transitions, guard interactions and the reset release of locked-down blocks are covered in a few hundred cycles.

// File: rtl/flk_pkg.sv
// Shared types for the flash block lock manager.
// Assumes two-bit encodings; the state encoding doubles as the status-word low bits.
package flk_pkg;

    // Per-block protection level; bit 0 = locked, bit 1 = locked-down.
    typedef enum logic [1:0] {
        LK_OPEN   = 2'b00,
        LK_HELD   = 2'b01,
        LK_PINNED = 2'b11
    } lk_state_e;

    // Decoded lock operations as delivered by the command decoder.
    typedef enum logic [1:0] {
        OP_NOP    = 2'b00,
        OP_LOCK   = 2'b01,
        OP_UNLOCK = 2'b10,
        OP_PIN    = 2'b11
    } lk_op_e;

endpackage

// File: rtl/flk_block_map.sv
// Maps a word address to a block index for a bottom-boot layout:
// NUM_PARAM small blocks of 2^PARAM_AW words from address zero, then
// main blocks of 2^MAIN_AW words up to the top of the address space.
// Assumes the parameter region fits below 2^ADDR_W. Purely combinational.
module flk_block_map #(
    parameter int ADDR_W    = 21,
    parameter int PARAM_AW  = 12,
    parameter int MAIN_AW   = 15,
    parameter int NUM_PARAM = 8,
    parameter int BLK_W     = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BLK_W-1:0]  blk_idx
);

    localparam int              PARAM_WORDS = NUM_PARAM << PARAM_AW;
    localparam logic [ADDR_W-1:0] PARAM_END = ADDR_W'(PARAM_WORDS);

    logic [ADDR_W-1:0] main_off;

    // Offset of the address into the main-block region.
    assign main_off = addr - PARAM_END;

    // Select the parameter or main block index.
    always_comb begin
        if (addr < PARAM_END) begin
            blk_idx = BLK_W'(addr >> PARAM_AW);
        end else begin
            blk_idx = BLK_W'(main_off >> MAIN_AW) + BLK_W'(NUM_PARAM);
        end
    end

endmodule

// File: rtl/flk_lock_cell.sv
// Holds the protection level of one block and applies lock commands to it.
// Assumes hit is high only when a valid command targets this block.
// Reset leaves the block locked; only reset clears a pinned block while guard_n is low.
module flk_lock_cell
    import flk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  lk_op_e    op,
    input  logic      guard_n,
    output lk_state_e state
);

    lk_state_e state_q;
    lk_state_e state_d;

    // Next-state rule for one command addressed to this block.
    always_comb begin
        state_d = state_q;
        if (hit) begin
            case (op)
                OP_LOCK:   if (state_q == LK_OPEN) state_d = LK_HELD;
                OP_UNLOCK: if (state_q != LK_PINNED || guard_n) state_d = LK_OPEN;
                OP_PIN:    state_d = LK_PINNED;
                default:   state_d = state_q;
            endcase
        end
    end

    // State register; reset forces the locked level.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_HELD;
        else        state_q <= state_d;
    end

    assign state = state_q;

    AST_RESET_LOCKS: assert property (@(posedge clk) !rst_n |=> state_q == LK_HELD); // R1
    AST_PIN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_PIN) |=> state_q == LK_PINNED); // R5
    AST_PIN_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_PINNED && !guard_n) |=> state_q == LK_PINNED); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state_q)); // R7
    AST_LOCK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && op == OP_LOCK && state_q != LK_OPEN) |=> $stable(state_q)); // R3

endmodule

// File: rtl/flk_lock_mgr.sv
// Top of the flash block lock manager. Decodes command, modify and status
// addresses to block indices, keeps one lock cell per block, answers modify
// requests with a same-cycle allow flag and a next-cycle error pulse, and
// returns the lock status word for signature reads.
// Assumes the command decoder presents one decoded lock command per cycle.
module flk_lock_mgr
    import flk_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int PARAM_AW  = 12,
    parameter int MAIN_AW   = 15,
    parameter int NUM_PARAM = 8,
    parameter int SIG_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              guard_n,
    input  logic              mod_req,
    input  logic [ADDR_W-1:0] mod_addr,
    output logic              mod_allow,
    output logic              prot_err,
    input  logic [ADDR_W-1:0] sig_addr,
    output logic [SIG_W-1:0]  sig_status
);

    localparam int NUM_MAIN   = ((1 << ADDR_W) - (NUM_PARAM << PARAM_AW)) >> MAIN_AW;
    localparam int NUM_BLOCKS = NUM_PARAM + NUM_MAIN;
    localparam int BLK_W      = $clog2(NUM_BLOCKS);

    logic [BLK_W-1:0] cmd_idx;
    logic [BLK_W-1:0] mod_idx;
    logic [BLK_W-1:0] sig_idx;
    lk_state_e        blk_state [NUM_BLOCKS];
    lk_op_e           op_dec;

    assign op_dec = lk_op_e'(cmd_op);

    flk_block_map #(
        .ADDR_W(ADDR_W), .PARAM_AW(PARAM_AW), .MAIN_AW(MAIN_AW),
        .NUM_PARAM(NUM_PARAM), .BLK_W(BLK_W)
    ) u_map_cmd (
        .addr(cmd_addr), .blk_idx(cmd_idx)
    );

    flk_block_map #(
        .ADDR_W(ADDR_W), .PARAM_AW(PARAM_AW), .MAIN_AW(MAIN_AW),
        .NUM_PARAM(NUM_PARAM), .BLK_W(BLK_W)
    ) u_map_mod (
        .addr(mod_addr), .blk_idx(mod_idx)
    );

    flk_block_map #(
        .ADDR_W(ADDR_W), .PARAM_AW(PARAM_AW), .MAIN_AW(MAIN_AW),
        .NUM_PARAM(NUM_PARAM), .BLK_W(BLK_W)
    ) u_map_sig (
        .addr(sig_addr), .blk_idx(sig_idx)
    );

    // One lock cell per block, selected by the decoded command index.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
        flk_lock_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (cmd_valid && (cmd_idx == BLK_W'(b))),
            .op     (op_dec),
            .guard_n(guard_n),
            .state  (blk_state[b])
        );
    end

    // Modify permission follows the addressed block with no latency.
    assign mod_allow = (blk_state[mod_idx] == LK_OPEN);

    // Signature word carries the two lock bits in its low positions.
    assign sig_status = {{(SIG_W-2){1'b0}}, blk_state[sig_idx]};

    // Protection error pulse for a denied modify attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) prot_err <= 1'b0;
        else        prot_err <= mod_req && !mod_allow;
    end

    AST_DENY_RAISES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !mod_allow) |=> prot_err); // R10
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> $past(mod_req && !mod_allow)); // R10
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cmd_idx) < NUM_BLOCKS); // R2
    AST_ALLOW_AGREES_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_idx == mod_idx && mod_allow) |-> sig_status[1:0] == 2'b00); // R9

endmodule

// File: tb/test_flk_lock_mgr.sv
// Scoreboard bench: driver tasks push expected results into a queue,
// a monitor pops them and compares with the design outputs.
module test_flk_lock_mgr;

    localparam int ADDR_W = 12;
    localparam int PAW    = 6;
    localparam int MAW    = 9;
    localparam int NP     = 8;
    localparam int SIG_W  = 16;
    localparam int NB     = NP + ((1 << ADDR_W) - (NP << PAW)) / (1 << MAW);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic              guard_n = 1'b1;
    logic              mod_req = 1'b0;
    logic [ADDR_W-1:0] mod_addr = '0;
    logic              mod_allow;
    logic              prot_err;
    logic [ADDR_W-1:0] sig_addr = '0;
    logic [SIG_W-1:0]  sig_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [17:0] exp;
    } item_t;

    item_t exp_q[$];
    logic [1:0] mdl [NB];

    always #4 clk = ~clk;

    flk_lock_mgr #(
        .ADDR_W(ADDR_W), .PARAM_AW(PAW), .MAIN_AW(MAW), .NUM_PARAM(NP), .SIG_W(SIG_W)
    ) i_flk_lock_mgr (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .guard_n(guard_n), .mod_req(mod_req),
        .mod_addr(mod_addr), .mod_allow(mod_allow), .prot_err(prot_err),
        .sig_addr(sig_addr), .sig_status(sig_status)
    );

    // R2 reference map of word address to block number.
    function automatic int blk_of(input int a);
        if (a < (NP << PAW)) return a >> PAW;
        return NP + ((a - (NP << PAW)) >> MAW);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++) mdl[b] = 2'b01;
    endtask

    // Issue one command and update the reference state.
    task automatic lock_cmd(input int a, input logic [1:0] op);
        int b;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = ADDR_W'(a);
        @(negedge clk);
        cmd_valid = 1'b0;
        b = blk_of(a);
        case (op)
            2'b01: if (mdl[b] == 2'b00) mdl[b] = 2'b01;
            2'b10: if (mdl[b] != 2'b11 || guard_n) mdl[b] = 2'b00;
            2'b11: mdl[b] = 2'b11;
            default: ;
        endcase
    endtask

    // Probe a block with a modify attempt and a status read.
    task automatic probe(input int a, input string tag);
        item_t it;
        logic [1:0] s;
        @(negedge clk);
        s        = mdl[blk_of(a)];
        mod_req  = 1'b1;
        mod_addr = ADDR_W'(a);
        sig_addr = ADDR_W'(a);
        it.tag   = tag;
        it.exp   = {14'b0, s, (s == 2'b00), (s != 2'b00)};
        exp_q.push_back(it);
        @(negedge clk);
        mod_req = 1'b0;
    endtask

    // Monitor: compare one queued item per cycle after the edge settles.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                item_t it;
                logic [17:0] act;
                it  = exp_q.pop_front();
                act = {sig_status, mod_allow, prot_err};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 R11 R9 R10: every block locked after reset.
        for (int b = 0; b < NB; b++) begin
            int base;
            base = (b < NP) ? (b << PAW) : ((NP << PAW) + ((b - NP) << MAW));
            probe(base, "R1 reset locked");
        end
        // R4 R7 R8 R2: unlock one parameter block by an inner address.
        lock_cmd(3 * 64 + 5, 2'b10);
        probe(3 * 64, "R4 unlock param block");
        probe(2 * 64 + 63, "R7 neighbour below untouched");
        probe(4 * 64, "R7 neighbour above untouched");
        // R2: boundary between parameter and main region.
        lock_cmd(12'h1FF, 2'b10);
        probe(12'h1C0, "R2 last param block");
        probe(12'h200, "R2 first main block");
        lock_cmd(12'hFFF, 2'b10);
        probe(12'hE00, "R2 last main block");
        probe(12'hDFF, "R2 block before last");
        // R7: no-op code leaves state.
        lock_cmd(3 * 64, 2'b00);
        probe(3 * 64 + 10, "R7 nop ignored");
        // R3: lock an unlocked block.
        lock_cmd(3 * 64 + 1, 2'b01);
        probe(3 * 64, "R3 lock unlocked");
        // R5 R11: lock-down from locked.
        lock_cmd(5 * 64, 2'b11);
        probe(5 * 64, "R5 lockdown from locked");
        // R3: lock on locked-down keeps it.
        lock_cmd(5 * 64, 2'b01);
        probe(5 * 64, "R3 lock keeps lockdown");
        // R6: guard low blocks release.
        guard_n = 1'b0;
        lock_cmd(5 * 64, 2'b10);
        probe(5 * 64, "R6 unlock rejected while guarded");
        // R4: guard high releases.
        guard_n = 1'b1;
        lock_cmd(5 * 64, 2'b10);
        probe(5 * 64, "R4 unlock pinned with guard high");
        // R5: lock-down from unlocked and from locked while guarded.
        guard_n = 1'b0;
        lock_cmd(12'hFFF, 2'b11);
        probe(12'hE40, "R5 lockdown from unlocked");
        lock_cmd(5 * 64, 2'b11);
        probe(5 * 64, "R5 lockdown again");
        // R1: reset clears locked-down back to locked.
        do_reset();
        probe(5 * 64, "R1 reset clears lockdown");
        probe(12'hE00, "R1 reset clears lockdown main");
        probe(12'h200, "R1 reset relocks unlocked");
        // R4 R6: after reset a guarded unlock succeeds.
        lock_cmd(5 * 64, 2'b10);
        probe(5 * 64, "R4 unlock after reset guarded");
        guard_n = 1'b1;
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule